// File: doc/BRIEF.md
# Replay-capable FIFO buffer with half-full flag

This block is a single-clock first-in/first-out buffer for 9-bit words, with a depth set by a parameter. A producer requests a write by pulling `wr_n` low and a consumer requests a read by pulling `rd_n` low. Each strobe is sampled at every rising clock edge as a one-cycle enable, so a strobe held low for several cycles makes several requests. Three active-low flags report the buffer's state: empty, full, and more-than-half-full. A write into a full buffer is dropped, and so is a read from an empty one.

A rewind input, `rtx_n`, moves the read side back to the first storage location and leaves the write side where it is. Words already consumed can then be replayed, as long as no more than the depth has been written since reset. Read data is registered. A `dout_vld` strobe marks each cycle that carries a delivered word, and `dout` is forced to zero in all other cycles. Reset is synchronous and active high.

Top module: `rewind_fifo`

## Requirements
- R1: After a synchronous reset, `empty_n`=0, `full_n`=1, `half_n`=1 and `dout_vld`=0. Both pointers are at location zero, so the first word written afterwards is the first word read.
- R2: A write request (`wr_n`=0) sampled while the buffer holds DEPTH words is dropped. Occupancy and stored contents do not change.
- R3: A read request (`rd_n`=0) sampled while the buffer is empty is dropped. `dout_vld` stays 0 and `empty_n` stays 0.
- R4: Words are read back in the order in which they were written. `dout` and `dout_vld`=1 appear right after the edge that accepts the read. `dout` is 0 whenever `dout_vld` is 0.
- R5: Starting from reset with no reads, `full_n` goes to 0 right after the edge of the DEPTH-th accepted write. `empty_n` goes to 0 right after the edge of the read that takes the last stored word.
- R6: `half_n` is 0 exactly when occupancy exceeds DEPTH/2. It falls after the write that crosses above half. It rises after the read that brings occupancy back to DEPTH/2 or below.
- R7: When the buffer is neither empty nor full, a read and a write sampled at the same edge are both accepted and the occupancy does not change.
- R8: A rewind (`rtx_n`=0 with `wr_n`=1 and `rd_n`=1) sets the read pointer to location zero and keeps the write pointer. Occupancy becomes the write pointer position, or DEPTH if the write pointer has wrapped back to zero. All flags follow the new occupancy.
- R9: A rewind request sampled while `wr_n` or `rd_n` is 0 is ignored. The concurrent access proceeds normally and reading continues from the current position.
- R10: If `rd_n` is held low while one word is written into an empty buffer, that word is delivered on the following edge with no further write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write request, active low, sampled each edge |
| rd_n | input | 1 | Read request, active low, sampled each edge |
| rtx_n | input | 1 | Rewind request, active low |
| din | input | DW | Write data |
| dout | output | DW | Read data, zero when not valid |
| dout_vld | output | 1 | High for one cycle per delivered word |
| empty_n | output | 1 | Low when no words are stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
Every result is due in the cycle right after the edge that samples the request. The flags are decoded directly from the registered occupancy, and the read word and its valid strobe are registered at that same edge. The bench therefore drives each request, waits one rising edge plus a short delay, and samples there. The one exception is the flow-through case: there the write edge and the read edge are consecutive, so the word is checked one edge later than the write.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;

    // Accepted operations for the current cycle
    typedef struct packed {
        logic wr;
        logic rd;
        logic rtx;
    } acc_t;

    // True when an occupancy lies strictly above half of the depth
    function automatic bit above_half(int unsigned occ, int unsigned depth);
        return occ > (depth / 2);
    endfunction

endpackage

// File: rtl/rf_store.sv
module rf_store #(
    parameter int DW    = 9,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          rvld
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read port; data forced to zero outside a delivered word
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            rvld  <= 1'b0;
        end else if (re) begin
            rdata <= mem[raddr];
            rvld  <= 1'b1;
        end else begin
            rdata <= '0;
            rvld  <= 1'b0;
        end
    end
endmodule

// File: rtl/rf_track.sv
module rf_track
    import rewind_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic          rtx_req,
    output acc_t          acc,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] occ
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam bit            POW2     = (DEPTH & (DEPTH - 1)) == 0;

    logic [AW-1:0] wr_nxt, rd_nxt;
    logic [CW-1:0] rewind_occ;
    logic          wrapped;

    generate
        if (POW2) begin : g_wrap_free
            assign wr_nxt = wr_ptr + AW'(1);
            assign rd_nxt = rd_ptr + AW'(1);
        end else begin : g_wrap_cmp
            assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
        end
    endgenerate

    always_comb begin
        acc.wr  = wr_req && (occ != FULL_CNT);
        acc.rd  = rd_req && (occ != '0);
        acc.rtx = rtx_req && !wr_req && !rd_req;
    end

    assign rewind_occ = (wrapped && wr_ptr == '0) ? FULL_CNT : {1'b0, wr_ptr};

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            occ     <= '0;
            wrapped <= 1'b0;
        end else if (acc.rtx) begin
            rd_ptr <= '0;
            occ    <= rewind_occ;
        end else begin
            if (acc.wr) begin
                wr_ptr <= wr_nxt;
                if (wr_nxt == '0) wrapped <= 1'b1;
            end
            if (acc.rd) rd_ptr <= rd_nxt;
            occ <= occ + CW'(acc.wr) - CW'(acc.rd);
        end
    end

    // R2
    wr_hold_full_chk: assert property (@(posedge clk) disable iff (rst)
        (occ == FULL_CNT) |=> $stable(wr_ptr));
    // R3
    rd_hold_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (occ == '0 && !rtx_req) |=> $stable(rd_ptr));
    // R7
    occ_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (occ != '0 && occ != FULL_CNT && wr_req && rd_req) |=> $stable(occ));
    // R9
    rtx_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (rtx_req && rd_req && !wr_req && occ != '0) |=> (occ == $past(occ) - CW'(1)));
    // R5
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= FULL_CNT);
endmodule

// File: rtl/rf_flags.sv
module rf_flags
    import rewind_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] occ,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    always_comb begin
        empty_n = (occ != '0);
        full_n  = (occ != FULL_CNT);
        half_n  = !above_half(32'(occ), DEPTH);
    end

    // R5
    empty_full_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!empty_n && !full_n));
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
    import rewind_fifo_pkg::*;
#(
    parameter int DW    = 9,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          rtx_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_vld,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    acc_t          acc;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] occ;

    rf_track #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_track (
        .clk(clk), .rst(rst),
        .wr_req(!wr_n), .rd_req(!rd_n), .rtx_req(!rtx_n),
        .acc(acc), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .occ(occ)
    );

    rf_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .rst(rst),
        .we(acc.wr), .waddr(wr_ptr), .wdata(din),
        .re(acc.rd), .raddr(rd_ptr),
        .rdata(dout), .rvld(dout_vld)
    );

    rf_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
        .clk(clk), .rst(rst), .occ(occ),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    // R4
    vld_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        dout_vld |-> ($past(!rd_n) && $past(empty_n)));
    // R4
    dout_zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !dout_vld |-> (dout == '0));
    // R6
    half_set_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(half_n) |-> ($past(!wr_n) || $past(!rtx_n)));
    // R6
    half_clr_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(half_n) |-> ($past(!rd_n) || $past(!rtx_n)));
endmodule

// File: tb/rewind_fifo_bench.sv
module rewind_fifo_bench;
    localparam int DW    = 9;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_n = 1'b1, rd_n = 1'b1, rtx_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_vld, empty_n, full_n, half_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rewind_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rewind_fifo (
        .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .rtx_n(rtx_n),
        .din(din), .dout(dout), .dout_vld(dout_vld),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_n = 1'b1; rd_n = 1'b1; rtx_n = 1'b1;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic push(input logic [DW-1:0] d);
        wr_n = 1'b0; din = d; tick(); wr_n = 1'b1;
    endtask

    task automatic pop_expect(input logic [DW-1:0] e, input string tag);
        rd_n = 1'b0; tick(); rd_n = 1'b1;
        check(dout_vld == 1'b1, tag, dout_vld, 1);
        check(dout == e, tag, dout, e);
    endtask

    task automatic t_reset();
        do_reset();
        check(empty_n == 1'b0, "R1 empty after reset", empty_n, 0);
        check(full_n == 1'b1, "R1 full after reset", full_n, 1);
        check(half_n == 1'b1, "R1 half after reset", half_n, 1);
        check(dout_vld == 1'b0, "R1 vld after reset", dout_vld, 0);
        push(9'h0A5);
        pop_expect(9'h0A5, "R1 first word from location zero");
    endtask

    task automatic t_empty_read();
        do_reset();
        rd_n = 1'b0; tick(); tick(); rd_n = 1'b1;
        check(dout_vld == 1'b0, "R3 read on empty dropped", dout_vld, 0);
        check(dout == '0, "R4 dout zero when idle", dout, 0);
        check(empty_n == 1'b0, "R3 still empty", empty_n, 0);
        push(9'h033);
        pop_expect(9'h033, "R3 pointer not moved by dropped read");
    endtask

    task automatic t_fill_drain();
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            push(9'(9'h100 + i));
            if (i == DEPTH/2 - 1) check(half_n == 1'b1, "R6 half high at exactly half", half_n, 1);
            if (i == DEPTH/2)     check(half_n == 1'b0, "R6 half low above half", half_n, 0);
            if (i == DEPTH - 2)   check(full_n == 1'b1, "R5 not full one short", full_n, 1);
        end
        check(full_n == 1'b0, "R5 full after DEPTH writes", full_n, 0);
        push(9'h1FF);
        check(full_n == 1'b0, "R2 still full after dropped write", full_n, 0);
        for (int i = 0; i < DEPTH; i++) begin
            pop_expect(9'(9'h100 + i), "R4 order after fill");
            if (i == DEPTH/2 - 2) check(half_n == 1'b0, "R6 half low above half on drain", half_n, 0);
            if (i == DEPTH/2 - 1) check(half_n == 1'b1, "R6 half rises at half", half_n, 1);
        end
        check(empty_n == 1'b0, "R5 empty after last read", empty_n, 0);
        rd_n = 1'b0; tick(); rd_n = 1'b1;
        check(dout_vld == 1'b0, "R2 dropped write not stored", dout_vld, 0);
        // Wrapped write pointer: rewind gives a full replay
        rtx_n = 1'b0; tick(); rtx_n = 1'b1;
        check(full_n == 1'b0, "R8 rewind after wrap is full", full_n, 0);
        pop_expect(9'h100, "R8 replay after wrap");
    endtask

    task automatic t_simul();
        do_reset();
        push(9'h010); push(9'h011); push(9'h012);
        for (int i = 0; i < 4; i++) begin
            wr_n = 1'b0; rd_n = 1'b0; din = 9'(9'h013 + i);
            tick();
            check(dout == 9'(9'h010 + i) && dout_vld, "R7 simultaneous read data", dout, 9'h010 + i);
        end
        wr_n = 1'b1; rd_n = 1'b1;
        pop_expect(9'h014, "R7 occupancy kept");
        pop_expect(9'h015, "R7 occupancy kept");
        pop_expect(9'h016, "R7 occupancy kept");
        check(empty_n == 1'b0, "R7 empty after three reads", empty_n, 0);
    endtask

    task automatic t_rewind();
        do_reset();
        for (int i = 0; i < 5; i++) push(9'(9'h050 + i));
        for (int i = 0; i < 5; i++) pop_expect(9'(9'h050 + i), "R4 first pass");
        check(empty_n == 1'b0, "R8 empty before rewind", empty_n, 0);
        rtx_n = 1'b0; tick(); rtx_n = 1'b1;
        check(empty_n == 1'b1, "R8 not empty after rewind", empty_n, 1);
        check(half_n == 1'b1, "R8 half after rewind of five", half_n, 1);
        for (int i = 0; i < 5; i++) pop_expect(9'(9'h050 + i), "R8 replay");
        check(empty_n == 1'b0, "R8 write pointer kept", empty_n, 0);
        // Rewind together with a read is ignored
        do_reset();
        push(9'h0C0); push(9'h0C1); push(9'h0C2);
        rtx_n = 1'b0; rd_n = 1'b0; tick(); rtx_n = 1'b1; rd_n = 1'b1;
        check(dout == 9'h0C0, "R9 read during rewind", dout, 9'h0C0);
        pop_expect(9'h0C1, "R9 rewind ignored");
        rtx_n = 1'b0; wr_n = 1'b0; din = 9'h0C3; tick(); rtx_n = 1'b1; wr_n = 1'b1;
        pop_expect(9'h0C2, "R9 rewind with write ignored");
        pop_expect(9'h0C3, "R9 write during rewind stored");
    endtask

    task automatic t_flow();
        do_reset();
        rd_n = 1'b0;
        wr_n = 1'b0; din = 9'h1A7; tick(); wr_n = 1'b1;
        check(dout_vld == 1'b0, "R10 no data at write edge", dout_vld, 0);
        check(empty_n == 1'b1, "R10 not empty after write", empty_n, 1);
        tick();
        check(dout_vld == 1'b1 && dout == 9'h1A7, "R10 flow-through word", dout, 9'h1A7);
        check(empty_n == 1'b0, "R10 empty again", empty_n, 0);
        tick();
        rd_n = 1'b1;
        check(dout_vld == 1'b0, "R10 single delivery", dout_vld, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_empty_read();
        t_fill_drain();
        t_simul();
        t_rewind();
        t_flow();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule